// File: doc/BRIEF.md
# Hexagonal-Grid Nearest-Vector and Duty Calculator

This block performs the geometric core of space-vector modulation on a grid whose two axes meet at 60 degrees. Each clock it may accept one reference point, given as two signed fixed-point coordinates (g and h) with a valid strobe. It picks the three grid vectors that enclose the reference and the fraction of the switching period for which each of them is applied. The reference must already be expressed in the 60-degree frame. The duties are handed on to a separate timing generator.

The integer part of each coordinate is its floor. The next grid line up is always floor plus one, even when the fraction is zero, so the enclosing cell is never degenerate. The cell is a rhombus split into a lower and an upper triangle. One comparison, on whether the two fractional parts add up to more than one, chooses the triangle. The two "mixed" corners of the rhombus are always used. The triangle decides whether the third vector is the low corner or the high corner. The block is pipelined with a fixed latency of two cycles and takes a new reference every clock.

Top module: `hexsvm_nearest`

## Requirements
- R1: Let floor(x) be the reference shifted right arithmetically by FRAC_W bits, and let ceil = floor + 1 in every case, including a zero fraction. Vector A is (floor g + 1, floor h) and vector B is (floor g, floor h + 1).
- R2: `tri_upper` is 1 exactly when frac g + frac h is greater than 1.0 (256 with FRAC_W = 8). Here a fraction is the low FRAC_W bits read unsigned. Vector C is (floor g + 1, floor h + 1) when `tri_upper` is 1 and (floor g, floor h) otherwise. A sum of exactly 1.0 selects the lower triangle.
- R3: Lower triangle: duty A = frac g, duty B = frac h, duty C = 1.0 − duty A − duty B.
- R4: Upper triangle: duty A = 1.0 − frac h, duty B = 1.0 − frac g, duty C = 1.0 − duty A − duty B.
- R5: Duties are unsigned with FRAC_W fractional bits and FRAC_W+1 bits in all, so 1.0 is 2^FRAC_W. Each duty lies in [0, 1.0], and on every valid output the three add up to exactly 1.0.
- R6: `out_valid` equals `in_valid` delayed by exactly two clocks. Back-to-back references produce back-to-back results in order.
- R7: While reset is low, `out_valid` is 0 and every output is 0.
- R8: Negative references round toward minus infinity: −0.25 gives floor −1 and a fraction of 0.75.
- R9: At the extremes of the reference range, the high corner is still correct because vectors are one bit wider than the integer part. For example, a reference of 0x7FFF gives a ceiling of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Reference strobe |
| ref_g | input | REF_W | Reference g coordinate, signed, FRAC_W fractional bits |
| ref_h | input | REF_W | Reference h coordinate, signed, FRAC_W fractional bits |
| out_valid | output | 1 | Result strobe |
| vec_a_g | output | VEC_W | Vector A, g coordinate (signed integer) |
| vec_a_h | output | VEC_W | Vector A, h coordinate |
| vec_b_g | output | VEC_W | Vector B, g coordinate |
| vec_b_h | output | VEC_W | Vector B, h coordinate |
| vec_c_g | output | VEC_W | Third vector, g coordinate |
| vec_c_h | output | VEC_W | Third vector, h coordinate |
| duty_a | output | DUTY_W | Duty of vector A |
| duty_b | output | DUTY_W | Duty of vector B |
| duty_c | output | DUTY_W | Duty of third vector |
| tri_upper | output | 1 | 1 when the upper triangle was chosen |

## Verification
The bench uses the default parameters: REF_W = 16 and FRAC_W = 8, giving 9-bit vectors and 9-bit duties. With these values, hand-computed references reach the most positive and most negative codes. It can therefore check that a ceiling of 128 and a floor of −128 come out without wrap. The tie case, where the fractions sum to exactly 256, and the zero-fraction case fall on exact code points. This lets the triangle choice and a zero or full-scale duty be pinned to single values.

// File: rtl/hexsvm_pkg.sv
package hexsvm_pkg;

    typedef enum logic {
        TRI_LOWER = 1'b0,
        TRI_UPPER = 1'b1
    } tri_e;

endpackage

// File: rtl/hexsvm_split.sv
module hexsvm_split #(
    parameter int REF_W  = 16,
    parameter int FRAC_W = 8,
    parameter int VEC_W  = REF_W - FRAC_W + 1
) (
    input  logic [REF_W-1:0]        coord,
    output logic signed [VEC_W-1:0] flo,
    output logic [FRAC_W-1:0]       frac
);
    localparam int INT_W = REF_W - FRAC_W;
    localparam int EXT_W = VEC_W - INT_W;

    // Arithmetic floor: integer field, sign extended by one or more bits
    assign flo  = {{EXT_W{coord[REF_W-1]}}, coord[REF_W-1:FRAC_W]};
    assign frac = coord[FRAC_W-1:0];

endmodule

// File: rtl/hexsvm_tri.sv
module hexsvm_tri
    import hexsvm_pkg::*;
#(
    parameter int FRAC_W = 8
) (
    input  logic [FRAC_W-1:0] frac_g,
    input  logic [FRAC_W-1:0] frac_h,
    output tri_e              tri_sel
);
    localparam int          SUM_W = FRAC_W + 1;
    localparam logic [SUM_W-1:0] ONE = SUM_W'(1) << FRAC_W;

    logic [SUM_W-1:0] frac_sum;

    // Sum of fractions above one means the point lies past the rhombus diagonal
    assign frac_sum = {1'b0, frac_g} + {1'b0, frac_h};
    assign tri_sel  = (frac_sum > ONE) ? TRI_UPPER : TRI_LOWER;

endmodule

// File: rtl/hexsvm_duty.sv
module hexsvm_duty
    import hexsvm_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int DUTY_W = FRAC_W + 1
) (
    input  logic [FRAC_W-1:0] frac_g,
    input  logic [FRAC_W-1:0] frac_h,
    input  tri_e              tri_sel,
    output logic [DUTY_W-1:0] duty_a,
    output logic [DUTY_W-1:0] duty_b,
    output logic [DUTY_W-1:0] duty_c
);
    localparam int              WIDE_W = DUTY_W + 1;
    localparam logic [WIDE_W-1:0] ONE  = WIDE_W'(1) << FRAC_W;

    logic [WIDE_W-1:0] fg_w;
    logic [WIDE_W-1:0] fh_w;
    logic [WIDE_W-1:0] a_w;
    logic [WIDE_W-1:0] b_w;
    logic [WIDE_W-1:0] c_w;

    always_comb begin
        fg_w = WIDE_W'(frac_g);
        fh_w = WIDE_W'(frac_h);
        if (tri_sel == TRI_UPPER) begin
            a_w = ONE - fh_w;
            b_w = ONE - fg_w;
        end else begin
            a_w = fg_w;
            b_w = fh_w;
        end
        // Third duty absorbs whatever remains so the sum is exact
        c_w    = ONE - a_w - b_w;
        duty_a = a_w[DUTY_W-1:0];
        duty_b = b_w[DUTY_W-1:0];
        duty_c = c_w[DUTY_W-1:0];
    end

endmodule

// File: rtl/hexsvm_nearest.sv
module hexsvm_nearest
    import hexsvm_pkg::*;
#(
    parameter int REF_W  = 16,
    parameter int FRAC_W = 8,
    parameter int VEC_W  = REF_W - FRAC_W + 1,
    parameter int DUTY_W = FRAC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [REF_W-1:0] ref_g,
    input  logic signed [REF_W-1:0] ref_h,
    output logic                    out_valid,
    output logic signed [VEC_W-1:0] vec_a_g,
    output logic signed [VEC_W-1:0] vec_a_h,
    output logic signed [VEC_W-1:0] vec_b_g,
    output logic signed [VEC_W-1:0] vec_b_h,
    output logic signed [VEC_W-1:0] vec_c_g,
    output logic signed [VEC_W-1:0] vec_c_h,
    output logic [DUTY_W-1:0]       duty_a,
    output logic [DUTY_W-1:0]       duty_b,
    output logic [DUTY_W-1:0]       duty_c,
    output logic                    tri_upper
);
    localparam int NCOORD = 2;
    localparam int AX_G   = 0;
    localparam int AX_H   = 1;

    typedef struct packed {
        logic                    vld;
        logic signed [VEC_W-1:0] flo_g;
        logic signed [VEC_W-1:0] flo_h;
        logic [FRAC_W-1:0]       fr_g;
        logic [FRAC_W-1:0]       fr_h;
        tri_e                    tri_sel;
    } stg1_t;

    typedef struct packed {
        logic                    vld;
        logic signed [VEC_W-1:0] a_g;
        logic signed [VEC_W-1:0] a_h;
        logic signed [VEC_W-1:0] b_g;
        logic signed [VEC_W-1:0] b_h;
        logic signed [VEC_W-1:0] c_g;
        logic signed [VEC_W-1:0] c_h;
        logic [DUTY_W-1:0]       d_a;
        logic [DUTY_W-1:0]       d_b;
        logic [DUTY_W-1:0]       d_c;
        tri_e                    tri_sel;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    logic [REF_W-1:0]        coord   [NCOORD];
    logic signed [VEC_W-1:0] flo_w   [NCOORD];
    logic [FRAC_W-1:0]       frac_w  [NCOORD];
    tri_e                    tri_w;
    logic [DUTY_W-1:0]       da_w;
    logic [DUTY_W-1:0]       db_w;
    logic [DUTY_W-1:0]       dc_w;

    assign coord[AX_G] = ref_g;
    assign coord[AX_H] = ref_h;

    // Stage 1: split each coordinate into integer and fractional parts
    for (genvar k = 0; k < NCOORD; k++) begin : g_split
        hexsvm_split #(
            .REF_W  (REF_W),
            .FRAC_W (FRAC_W),
            .VEC_W  (VEC_W)
        ) u_split (
            .coord (coord[k]),
            .flo   (flo_w[k]),
            .frac  (frac_w[k])
        );
    end

    hexsvm_tri #(
        .FRAC_W (FRAC_W)
    ) u_tri (
        .frac_g  (frac_w[AX_G]),
        .frac_h  (frac_w[AX_H]),
        .tri_sel (tri_w)
    );

    // Stage 2: duties from the registered fractions
    hexsvm_duty #(
        .FRAC_W (FRAC_W),
        .DUTY_W (DUTY_W)
    ) u_duty (
        .frac_g  (s1_q.fr_g),
        .frac_h  (s1_q.fr_h),
        .tri_sel (s1_q.tri_sel),
        .duty_a  (da_w),
        .duty_b  (db_w),
        .duty_c  (dc_w)
    );

    always_comb begin
        s1_d         = s1_q;
        s1_d.vld     = in_valid;
        s1_d.flo_g   = flo_w[AX_G];
        s1_d.flo_h   = flo_w[AX_H];
        s1_d.fr_g    = frac_w[AX_G];
        s1_d.fr_h    = frac_w[AX_H];
        s1_d.tri_sel = tri_w;

        s2_d         = s2_q;
        s2_d.vld     = s1_q.vld;
        s2_d.a_g     = s1_q.flo_g + VEC_W'(1);
        s2_d.a_h     = s1_q.flo_h;
        s2_d.b_g     = s1_q.flo_g;
        s2_d.b_h     = s1_q.flo_h + VEC_W'(1);
        if (s1_q.tri_sel == TRI_UPPER) begin
            s2_d.c_g = s1_q.flo_g + VEC_W'(1);
            s2_d.c_h = s1_q.flo_h + VEC_W'(1);
        end else begin
            s2_d.c_g = s1_q.flo_g;
            s2_d.c_h = s1_q.flo_h;
        end
        s2_d.d_a     = da_w;
        s2_d.d_b     = db_w;
        s2_d.d_c     = dc_w;
        s2_d.tri_sel = s1_q.tri_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.vld;
    assign vec_a_g   = s2_q.a_g;
    assign vec_a_h   = s2_q.a_h;
    assign vec_b_g   = s2_q.b_g;
    assign vec_b_h   = s2_q.b_h;
    assign vec_c_g   = s2_q.c_g;
    assign vec_c_h   = s2_q.c_h;
    assign duty_a    = s2_q.d_a;
    assign duty_b    = s2_q.d_b;
    assign duty_c    = s2_q.d_c;
    assign tri_upper = (s2_q.tri_sel == TRI_UPPER);

endmodule

// File: rtl/hexsvm_nearest_chk.sv
module hexsvm_nearest_chk #(
    parameter int FRAC_W = 8,
    parameter int VEC_W  = 9,
    parameter int DUTY_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [VEC_W-1:0] vec_a_g,
    input logic signed [VEC_W-1:0] vec_a_h,
    input logic signed [VEC_W-1:0] vec_b_g,
    input logic signed [VEC_W-1:0] vec_b_h,
    input logic signed [VEC_W-1:0] vec_c_g,
    input logic signed [VEC_W-1:0] vec_c_h,
    input logic [DUTY_W-1:0]       duty_a,
    input logic [DUTY_W-1:0]       duty_b,
    input logic [DUTY_W-1:0]       duty_c,
    input logic                    tri_upper
);
    localparam int ONE = 1 << FRAC_W;

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_duty_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(duty_a) + int'(duty_b) + int'(duty_c)) == ONE);

    assert_duty_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(duty_a) <= ONE && int'(duty_b) <= ONE && int'(duty_c) <= ONE));

    assert_mixed_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (vec_a_g == vec_b_g + VEC_W'(1) && vec_b_h == vec_a_h + VEC_W'(1)));

    assert_third_vec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (tri_upper ? (vec_c_g == vec_a_g && vec_c_h == vec_b_h)
                                 : (vec_c_g == vec_b_g && vec_c_h == vec_a_h)));

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_reset_idle_R7: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && duty_a == '0 && duty_b == '0 && duty_c == '0));

endmodule

bind hexsvm_nearest hexsvm_nearest_chk #(
    .FRAC_W (FRAC_W),
    .VEC_W  (VEC_W),
    .DUTY_W (DUTY_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .vec_a_g   (vec_a_g),
    .vec_a_h   (vec_a_h),
    .vec_b_g   (vec_b_g),
    .vec_b_h   (vec_b_h),
    .vec_c_g   (vec_c_g),
    .vec_c_h   (vec_c_h),
    .duty_a    (duty_a),
    .duty_b    (duty_b),
    .duty_c    (duty_c),
    .tri_upper (tri_upper)
);

// File: tb/hexsvm_nearest_bench.sv
module hexsvm_nearest_bench;
    localparam int REF_W  = 16;
    localparam int FRAC_W = 8;
    localparam int VEC_W  = REF_W - FRAC_W + 1;
    localparam int DUTY_W = FRAC_W + 1;
    localparam int ONE    = 1 << FRAC_W;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [REF_W-1:0] ref_g = '0;
    logic signed [REF_W-1:0] ref_h = '0;
    logic                    out_valid;
    logic signed [VEC_W-1:0] vec_a_g, vec_a_h, vec_b_g, vec_b_h, vec_c_g, vec_c_h;
    logic [DUTY_W-1:0]       duty_a, duty_b, duty_c;
    logic                    tri_upper;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int e_ag, e_ah, e_bg, e_bh, e_cg, e_ch, e_da, e_db, e_dc, e_up;

    always #2 clk = ~clk;

    hexsvm_nearest #(
        .REF_W  (REF_W),
        .FRAC_W (FRAC_W)
    ) u_hexsvm_nearest (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .ref_g     (ref_g),
        .ref_h     (ref_h),
        .out_valid (out_valid),
        .vec_a_g   (vec_a_g),
        .vec_a_h   (vec_a_h),
        .vec_b_g   (vec_b_g),
        .vec_b_h   (vec_b_h),
        .vec_c_g   (vec_c_g),
        .vec_c_h   (vec_c_h),
        .duty_a    (duty_a),
        .duty_b    (duty_b),
        .duty_c    (duty_c),
        .tri_upper (tri_upper)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected result from the requirement formulas
    task automatic model(input int g, input int h);
        int fg, fh, flg, flh;
        flg = g >>> FRAC_W;
        flh = h >>> FRAC_W;
        fg  = g - flg * ONE;
        fh  = h - flh * ONE;
        e_up = (fg + fh > ONE) ? 1 : 0;
        e_ag = flg + 1; e_ah = flh;
        e_bg = flg;     e_bh = flh + 1;
        if (e_up == 1) begin
            e_cg = flg + 1; e_ch = flh + 1;
            e_da = ONE - fh; e_db = ONE - fg;
        end else begin
            e_cg = flg; e_ch = flh;
            e_da = fg; e_db = fh;
        end
        e_dc = ONE - e_da - e_db;
    endtask

    task automatic compare(input string req);
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "vec_a_g", int'(vec_a_g), e_ag);
        check(req, "vec_a_h", int'(vec_a_h), e_ah);
        check(req, "vec_b_g", int'(vec_b_g), e_bg);
        check(req, "vec_b_h", int'(vec_b_h), e_bh);
        check(req, "vec_c_g", int'(vec_c_g), e_cg);
        check(req, "vec_c_h", int'(vec_c_h), e_ch);
        check(req, "tri_upper", int'(tri_upper), e_up);
        check(req, "duty_a", int'(duty_a), e_da);
        check(req, "duty_b", int'(duty_b), e_db);
        check(req, "duty_c", int'(duty_c), e_dc);
        check("R5", "duty sum", int'(duty_a) + int'(duty_b) + int'(duty_c), ONE);
    endtask

    // One reference, result sampled two clocks later, then strobe checked low
    task automatic run_one(input string req, input int g, input int h);
        @(negedge clk);
        ref_g = REF_W'(g); ref_h = REF_W'(h); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        model(g, h);
        compare(req);
        @(negedge clk);
        check("R6", "out_valid after single", int'(out_valid), 0);
    endtask

    task automatic t_reset();
        check("R7", "out_valid in reset", int'(out_valid), 0);
        check("R7", "duty_a in reset", int'(duty_a), 0);
        check("R7", "vec_c_g in reset", int'(vec_c_g), 0);
    endtask

    task automatic t_lower();   run_one("R3", 16'sh0140, 16'sh0260); endtask // 1.25, 2.375
    task automatic t_upper();   run_one("R4", 16'sh0180, 16'sh00C0); endtask // 1.5, 0.75
    task automatic t_tie();     run_one("R2", 16'sh0080, 16'sh0380); endtask // sum exactly 1.0
    task automatic t_integer(); run_one("R1", 16'sh0300, -16'sh0200); endtask // zero fractions
    task automatic t_negative();run_one("R8", -16'sh0040, -16'sh0180); endtask // -0.25, -1.5
    task automatic t_top();     run_one("R9", 16'sh7FFF, 16'sh7FFF); endtask
    task automatic t_bottom();  run_one("R9", -32768, 16'sh7F00); endtask

    task automatic t_burst();
        int gs [5] = '{16'sh0010, 16'sh00F0, -16'sh0101, 16'sh0a80, 16'sh0155};
        int hs [5] = '{16'sh0020, 16'sh00F0, 16'sh00FF, -16'sh0a80, -16'sh0033};
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                model(gs[i-2], hs[i-2]);
                compare("R6");
            end
            if (i < 5) begin
                ref_g = REF_W'(gs[i]); ref_h = REF_W'(hs[i]); in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R6", "out_valid after burst", int'(out_valid), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lower();
        t_upper();
        t_tie();
        t_integer();
        t_negative();
        t_top();
        t_bottom();
        t_burst();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule